// File: doc/BRIEF.md
# System Clock Resuscitation Watchdog

This block supervises a fast system clock from a slower, always-running reference clock. A toggle flop in the system-clock domain is carried into the reference domain through a short synchroniser chain. Each toggle the reference side observes reloads a down-counter from a programmable 8-bit timeout. If detection is enabled and the counter sits at zero with no toggle seen, the block raises a sticky resuscitate request. A downstream clock multiplexer uses this request to move the system onto a safe source.

Software can also raise the request on purpose through a force control, to exercise the recovery path. Once the fault is repaired, the flag is dropped with a one-cycle clear pulse. The flag also drives an interrupt. The interrupt appears as a raw view and as a masked view that honours an interrupt enable and an interrupt force. All control inputs and outputs belong to the reference-clock domain.

Top module: `clk_resus_watchdog`

## Requirements
- R1: After reset the timeout register reads 0xFF on `tmo_value`. A cycle with `tmo_we` high loads `tmo_wdata`, and the new value appears on `tmo_value` after that edge.
- R2: With detection enabled and the system clock toggling, `resus_req` stays low for any timeout of 3 or more.
- R3: With detection enabled and the system clock stopped, `resus_req` is still low T reference edges after the edge that samples `clear_pulse`, and it is high after edge T+1, where T is the current timeout (0 to 255).
- R4: While `det_enable` is low, a stopped system clock never raises `resus_req`.
- R5: A cycle with `force_event` high sets `resus_req` on the next edge, even when the system clock is healthy or detection is disabled.
- R6: Once set, `resus_req` stays high until an edge samples `clear_pulse`. Clear takes priority over force and over a detected fault in the same cycle.
- R7: A clear pulse when the flag is already low leaves it low and reloads the counter, so a dead clock is reported T+1 edges after the latest clear.
- R8: `irq_raw` equals the resuscitate flag.
- R9: `irq_masked` equals (`irq_raw` AND `irq_enable`) OR `irq_force`.
- R10: After reset `resus_req` and `irq_raw` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all control and status are in this domain |
| ref_rst_n | input | 1 | Asynchronous active-low reset for the reference domain |
| sys_clk | input | 1 | Supervised system clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset for the system-clock toggle flop |
| tmo_we | input | 1 | Write strobe for the timeout register |
| tmo_wdata | input | 8 | New timeout value, in reference-clock cycles |
| tmo_value | output | 8 | Current timeout register |
| det_enable | input | 1 | Enables stopped-clock detection |
| force_event | input | 1 | Raises a resuscitation event for testing |
| clear_pulse | input | 1 | One-cycle pulse that drops the flag and reloads the counter |
| irq_enable | input | 1 | Interrupt enable for the masked view |
| irq_force | input | 1 | Forces the masked interrupt high |
| resus_req | output | 1 | Sticky resuscitate request and status flag |
| irq_raw | output | 1 | Raw interrupt, mirrors the flag |
| irq_masked | output | 1 | Masked and forced interrupt |

## Verification
The checker watches several relations on every reference edge. It confirms that force sets the flag, that the flag holds until a clear, that a clear always drops it, that the raw interrupt tracks the flag, that irq_force drives the masked output, and that the flag cannot rise with detection and force both off. The exact latency from a clear to the request under a stopped clock is shown only by the bench scenarios, as is the absence of false triggers under a running clock and the timeout reset value. Those scenarios include the zero timeout and a clear repeated mid-countdown.

// File: rtl/clk_resus_pkg.sv
package clk_resus_pkg;
  localparam int unsigned TMO_W       = 8;
  localparam logic [TMO_W-1:0] TMO_RST = '1;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/resus_sync.sv
// Multi-stage synchroniser with asynchronous active-low reset.
module resus_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/resus_toggle.sv
// System-clock domain: a flop that inverts on every system clock edge.
module resus_toggle (
  input  logic clk,
  input  logic rst_n,
  output logic tog
);
  logic tog_q;
  logic tog_d;

  always_comb tog_d = ~tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  assign tog = tog_q;
endmodule

// File: rtl/resus_timer.sv
// Reference domain: edge detect, timeout register, down-counter, sticky flag.
module resus_timer
  import clk_resus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tog_sync,
  input  logic             enable,
  input  logic             force_ev,
  input  logic             clear,
  input  logic             tmo_we,
  input  logic [TMO_W-1:0] tmo_wdata,
  output logic [TMO_W-1:0] tmo_q,
  output logic             flag
);
  logic             prev_q;
  logic [TMO_W-1:0] tmo_d;
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             sys_edge;
  logic             reload;
  logic             fault;
  logic             cnt_zero;

  always_comb begin
    sys_edge = tog_sync ^ prev_q;
    cnt_zero = (cnt_q == '0);
    reload   = clear | sys_edge | ~enable;
    fault    = enable & ~sys_edge & cnt_zero;

    tmo_d = tmo_q;
    if (tmo_we) tmo_d = tmo_wdata;

    cnt_d = cnt_q;
    if (reload)         cnt_d = tmo_q;
    else if (!cnt_zero) cnt_d = cnt_q - 1'b1;

    flag_d = flag_q | fault | force_ev;
    if (clear) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      tmo_q  <= TMO_RST;
      cnt_q  <= TMO_RST;
      flag_q <= 1'b0;
    end else begin
      prev_q <= tog_sync;
      tmo_q  <= tmo_d;
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/resus_irq.sv
// Interrupt views derived from the sticky flag.
module resus_irq (
  input  logic flag,
  input  logic irq_en,
  input  logic irq_frc,
  output logic raw,
  output logic masked
);
  always_comb begin
    raw    = flag;
    masked = (flag & irq_en) | irq_frc;
  end
endmodule

// File: rtl/clk_resus_watchdog.sv
module clk_resus_watchdog
  import clk_resus_pkg::*;
(
  input  logic             ref_clk,
  input  logic             ref_rst_n,
  input  logic             sys_clk,
  input  logic             sys_rst_n,
  input  logic             tmo_we,
  input  logic [TMO_W-1:0] tmo_wdata,
  output logic [TMO_W-1:0] tmo_value,
  input  logic             det_enable,
  input  logic             force_event,
  input  logic             clear_pulse,
  input  logic             irq_enable,
  input  logic             irq_force,
  output logic             resus_req,
  output logic             irq_raw,
  output logic             irq_masked
);
  logic rst_ref_n;
  logic rst_sys_n;
  logic sys_tog;
  logic tog_sync;
  logic flag;

  // Reset release synchronised to each domain, assertion stays asynchronous.
  resus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_ref (
    .clk(ref_clk), .rst_n(ref_rst_n), .d(1'b1), .q(rst_ref_n)
  );
  resus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sys (
    .clk(sys_clk), .rst_n(sys_rst_n), .d(1'b1), .q(rst_sys_n)
  );

  resus_toggle u_tog (
    .clk(sys_clk), .rst_n(rst_sys_n), .tog(sys_tog)
  );

  resus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tog_sync (
    .clk(ref_clk), .rst_n(rst_ref_n), .d(sys_tog), .q(tog_sync)
  );

  resus_timer u_timer (
    .clk       (ref_clk),
    .rst_n     (rst_ref_n),
    .tog_sync  (tog_sync),
    .enable    (det_enable),
    .force_ev  (force_event),
    .clear     (clear_pulse),
    .tmo_we    (tmo_we),
    .tmo_wdata (tmo_wdata),
    .tmo_q     (tmo_value),
    .flag      (flag)
  );

  resus_irq u_irq (
    .flag    (flag),
    .irq_en  (irq_enable),
    .irq_frc (irq_force),
    .raw     (irq_raw),
    .masked  (irq_masked)
  );

  assign resus_req = flag;
endmodule

// File: rtl/clk_resus_watchdog_chk.sv
module clk_resus_watchdog_chk (
  input logic clk,
  input logic rst_n,
  input logic det_enable,
  input logic force_event,
  input logic clear_pulse,
  input logic irq_force,
  input logic resus_req,
  input logic irq_raw,
  input logic irq_masked
);
  AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (force_event && !clear_pulse) |=> resus_req); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (resus_req && !clear_pulse) |=> resus_req); // R6
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_pulse |=> !resus_req); // R6
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_enable && !force_event && !resus_req) |=> !resus_req); // R4
  AST_RAW_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_raw == resus_req); // R8
  AST_MASK_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_force |-> irq_masked); // R9
endmodule

bind clk_resus_watchdog clk_resus_watchdog_chk u_chk (
  .clk         (ref_clk),
  .rst_n       (rst_ref_n),
  .det_enable  (det_enable),
  .force_event (force_event),
  .clear_pulse (clear_pulse),
  .irq_force   (irq_force),
  .resus_req   (resus_req),
  .irq_raw     (irq_raw),
  .irq_masked  (irq_masked)
);

// File: tb/tb_clk_resus_watchdog.sv
`timescale 1ns/1ps
module tb_clk_resus_watchdog;
  logic       ref_clk = 1'b0;
  logic       sys_clk = 1'b0;
  logic       sys_run = 1'b1;
  logic       ref_rst_n, sys_rst_n;
  logic       tmo_we;
  logic [7:0] tmo_wdata;
  logic [7:0] tmo_value;
  logic       det_enable, force_event, clear_pulse, irq_enable, irq_force;
  logic       resus_req, irq_raw, irq_masked;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  clk_resus_watchdog dut (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
    .tmo_we(tmo_we), .tmo_wdata(tmo_wdata), .tmo_value(tmo_value),
    .det_enable(det_enable), .force_event(force_event), .clear_pulse(clear_pulse),
    .irq_enable(irq_enable), .irq_force(irq_force),
    .resus_req(resus_req), .irq_raw(irq_raw), .irq_masked(irq_masked)
  );

  always #4 ref_clk = ~ref_clk;   // 125 MHz
  initial forever begin
    #10;
    if (sys_run) sys_clk = ~sys_clk;
  end

  function automatic logic exp_masked(logic raw, logic en, logic frc);
    return (raw & en) | frc;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  task automatic write_tmo(input logic [7:0] v);
    tmo_we = 1'b1; tmo_wdata = v;
    cyc(1);
    tmo_we = 1'b0;
  endtask

  task automatic pulse_clear();
    clear_pulse = 1'b1;
    cyc(1);
    clear_pulse = 1'b0;
  endtask

  // Clock must already be stopped and enable set; checks exact latency.
  task automatic latency(input int t, input string req);
    bit early = 1'b0;
    pulse_clear();
    check(resus_req == 1'b0, req, resus_req, 0);
    for (int i = 1; i <= t; i++) begin
      cyc(1);
      if (resus_req) early = 1'b1;
    end
    check(!early, req, early, 0);
    cyc(1);
    check(resus_req == 1'b1, req, resus_req, 1);
  endtask

  initial begin
    #1200000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    ref_rst_n = 0; sys_rst_n = 0;
    tmo_we = 0; tmo_wdata = 0; det_enable = 0; force_event = 0;
    clear_pulse = 0; irq_enable = 0; irq_force = 0;
    cyc(4);
    ref_rst_n = 1; sys_rst_n = 1;
    cyc(6);

    // R1 / R10: reset state
    check(tmo_value == 8'hFF, "R1", tmo_value, 255);
    check(resus_req == 1'b0, "R10", resus_req, 0);
    check(irq_raw == 1'b0, "R10", irq_raw, 0);
    check(irq_masked == 1'b0, "R9", irq_masked, 0);

    write_tmo(8'd5);
    check(tmo_value == 8'd5, "R1", tmo_value, 5);

    // R2: healthy clock, enabled, never triggers
    det_enable = 1'b1;
    pulse_clear();
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 300; i++) begin cyc(1); if (resus_req) seen = 1'b1; end
      check(!seen, "R2", seen, 0);
    end
    write_tmo(8'd3);
    pulse_clear();
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 300; i++) begin cyc(1); if (resus_req) seen = 1'b1; end
      check(!seen, "R2", seen, 0);
    end

    // R5 / R6: force while healthy, sticky, clear priority
    force_event = 1'b1; cyc(1); force_event = 1'b0;
    check(resus_req == 1'b1, "R5", resus_req, 1);
    cyc(20);
    check(resus_req == 1'b1, "R6", resus_req, 1);
    force_event = 1'b1; clear_pulse = 1'b1; cyc(1);
    force_event = 1'b0; clear_pulse = 1'b0;
    check(resus_req == 1'b0, "R6", resus_req, 0);

    // R4: stop clock with detection off; force still works
    det_enable = 1'b0;
    sys_run = 1'b0;
    write_tmo(8'd2);
    pulse_clear();
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 100; i++) begin cyc(1); if (resus_req) seen = 1'b1; end
      check(!seen, "R4", seen, 0);
    end
    force_event = 1'b1; cyc(1); force_event = 1'b0;
    check(resus_req == 1'b1, "R5", resus_req, 1);

    // R3: dead clock latency, directed corners
    det_enable = 1'b1;
    cyc(1);
    write_tmo(8'd0);  latency(0, "R3");
    write_tmo(8'd1);  latency(1, "R3");
    write_tmo(8'd10); latency(10, "R3");
    write_tmo(8'd255); latency(255, "R3");

    // R6: clear wins over a fault detected in the same cycle (timeout 0)
    write_tmo(8'd0);
    pulse_clear();
    cyc(1);
    check(resus_req == 1'b1, "R3", resus_req, 1);
    clear_pulse = 1'b1; cyc(1); clear_pulse = 1'b0;
    check(resus_req == 1'b0, "R6", resus_req, 0);

    // R7: clear when already clear reloads the counter
    write_tmo(8'd10);
    pulse_clear();
    cyc(5);
    check(resus_req == 1'b0, "R7", resus_req, 0);
    latency(10, "R7");

    // R3: random timeouts
    for (int k = 0; k < 20; k++) begin
      logic [7:0] t;
      t = 8'($urandom_range(0, 40));
      write_tmo(t);
      latency(int'(t), "R3");
    end

    // R8 / R9: random interrupt views
    for (int k = 0; k < 24; k++) begin
      bit want;
      want = 1'($urandom_range(0, 1));
      if (want) begin force_event = 1'b1; cyc(1); force_event = 1'b0; end
      else begin det_enable = 1'b0; pulse_clear(); end
      irq_enable = 1'($urandom_range(0, 1));
      irq_force  = 1'($urandom_range(0, 1));
      cyc(1);
      check(irq_raw == resus_req, "R8", irq_raw, resus_req);
      check(irq_masked == exp_masked(want, irq_enable, irq_force), "R9",
            irq_masked, exp_masked(want, irq_enable, irq_force));
      det_enable = 1'b1;
    end
    irq_force = 1'b0; irq_enable = 1'b0;

    sys_run = 1'b1;
    cyc(5);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule